// File: doc/BRIEF.md
# Periodic Sync Packet Scheduler

This block sits beside a trace packet generator and decides when a periodic synchronization packet should be inserted into the output stream. It keeps a running count of emitted trace bytes, which grows by 0 to 16 bytes per cycle. When the bytes emitted since the last synchronization point reach a programmable period, it raises a request. The request stays up until the downstream packetizer acknowledges it by emitting the sync packet.

The period is a power of two selected by a 4-bit frequency code. Code n gives 2048 << n bytes, so the range runs from 2 KiB to 64 MiB. Each new deadline is measured from the byte count at the acknowledge, not from the previous deadline. Late insertion therefore shifts the next deadline and does not pile up error.

Writes to the frequency code are validated against a per-code capability mask and a capability enable. Neighbouring reserved bits must be zero. The code can only change while tracing is off.

Top module: `ssp_top`

## Requirements
- R1: After reset, sync_req, cfg_fault and lock_err are 0 and cur_code is 0, which selects the 2 KiB period.
- R2: With code n active, tracing on and the capability on, sync_req rises on the clock edge that follows the first cycle in which the bytes counted since the current base reach 2048 << n. Bytes are counted, not cycles.
- R3: Once raised, sync_req stays high while tracing and the capability stay on and sync_ack is low. A cycle with sync_ack high while sync_req is high clears it at the next edge.
- R4: On an acknowledged cycle, the new base becomes the byte total accumulated before that cycle. The acknowledged cycle's own bytes count toward the next period.
- R5: byte_inc is added to the running total only while trace_en is high. Values above 16 are treated as 16.
- R6: While cap_periodic is low, sync_req is low from the next edge onward, and no request is made.
- R7: A configuration write, taken with trace_en low, whose code has its cap_mask bit clear raises cfg_fault for exactly one cycle and leaves cur_code unchanged.
- R8: A configuration write, taken with trace_en low, with a nonzero cfg_rsvd raises cfg_fault for one cycle and leaves cur_code unchanged.
- R9: A configuration write while trace_en is high is ignored: cur_code stays the same and cfg_fault stays low. It sets lock_err, which then stays high until reset.
- R10: While trace_en is low, any pending request is dropped at the next edge, and the base follows the total. A new period therefore starts when tracing resumes.
- R11: With cap_periodic low, a write of any nonzero code is rejected with cfg_fault. A write of code 0 that passes the mask and reserved-bit checks is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trace_en | input | 1 | Tracing enabled; gates byte counting and locks the code |
| cap_periodic | input | 1 | Capability enable for periodic sync requests |
| cap_mask | input | 16 | Bit n set means frequency code n is supported |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_code | input | 4 | Frequency code to write |
| cfg_rsvd | input | 4 | Reserved bits beside the code, must be zero |
| byte_inc | input | 5 | Bytes emitted this cycle (0 to 16, larger values clamped) |
| sync_ack | input | 1 | Packetizer has emitted the sync packet |
| sync_req | output | 1 | Sync packet insertion request |
| cfg_fault | output | 1 | One-cycle pulse after a rejected write |
| lock_err | output | 1 | Sticky flag for a write made while tracing |
| cur_code | output | 4 | Active frequency code |

## Verification
A directed run at a steady 16 bytes per cycle with code 0 places the first request on a known edge. This separates counting bytes from counting cycles and catches an off-by-one in the threshold compare. Random increments from 0 to 17, together with random and delayed acknowledges, check that each deadline is re-based at the acknowledge rather than at the previous deadline, and that oversized increments clamp. Further sequences are aimed at the configuration checks: mask-rejected codes, nonzero reserved bits, writes while tracing, and nonzero codes with the capability off. Each of these must show whether the code register moved, whether the fault pulse or the sticky lock flag fired, or both. Disabling tracing while a request is pending checks that the request drops and the period restarts.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int CODE_W    = 4;
  localparam int NCODES    = 1 << CODE_W;
  localparam int BASE_LOG2 = 11;
  localparam int RSV_W     = 4;
  localparam int INC_W     = 5;
  localparam int MAX_INC   = 16;
endpackage

// File: rtl/ssp_cfg.sv
module ssp_cfg
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              cap_periodic,
  input  logic [NCODES-1:0] cap_mask,
  input  logic              wr,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [RSV_W-1:0]  wr_rsvd,
  output logic [CODE_W-1:0] code_q,
  output logic              fault_q,
  output logic              lock_q
);
  logic [CODE_W-1:0] code_d;
  logic              fault_d;
  logic              lock_d;
  logic [NCODES-1:0] code_onehot;
  logic              supported;
  logic              bad;

  // one-hot decode of the requested code, masked by capability
  for (genvar g = 0; g < NCODES; g++) begin : g_dec
    assign code_onehot[g] = (wr_code == CODE_W'(g));
  end
  assign supported = |(code_onehot & cap_mask);

  assign bad = (wr_rsvd != '0) || !supported ||
               (!cap_periodic && (wr_code != '0));

  always_comb begin
    code_d  = code_q;
    fault_d = 1'b0;
    lock_d  = lock_q;
    if (wr) begin
      if (trace_en) begin
        lock_d = 1'b1;
      end else if (bad) begin
        fault_d = 1'b1;
      end else begin
        code_d = wr_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      fault_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      code_q  <= code_d;
      fault_q <= fault_d;
      lock_q  <= lock_d;
    end
  end
endmodule

// File: rtl/ssp_bytectr.sv
module ssp_bytectr
  import ssp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic [INC_W-1:0]  inc,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  localparam logic [INC_W-1:0] INC_LIM = INC_W'(MAX_INC);

  logic [CNT_W-1:0] tot_q, tot_d;
  logic [CNT_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] since;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] per_tab [NCODES];
  logic [INC_W-1:0] inc_eff;

  for (genvar g = 0; g < NCODES; g++) begin : g_per
    assign per_tab[g] = CNT_W'(1) << (BASE_LOG2 + g);
  end

  assign period  = per_tab[code];
  assign inc_eff = (inc > INC_LIM) ? INC_LIM : inc;
  assign since   = tot_q - base_q;
  assign hit     = (since >= period);

  always_comb begin
    tot_d  = tot_q;
    base_d = base_q;
    if (trace_en) tot_d = tot_q + CNT_W'(inc_eff);
    if (restart)  base_d = tot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q  <= '0;
      base_q <= '0;
    end else begin
      tot_q  <= tot_d;
      base_q <= base_d;
    end
  end
endmodule

// File: rtl/ssp_req.sv
module ssp_req (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  input  logic ack,
  output logic req_q,
  output logic restart
);
  logic req_d;
  logic taken;

  assign taken   = req_q && ack;
  assign restart = !en || taken;

  always_comb begin
    if (!en || taken) req_d = 1'b0;
    else              req_d = req_q || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/ssp_top.sv
module ssp_top
  import ssp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              cap_periodic,
  input  logic [NCODES-1:0] cap_mask,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic [RSV_W-1:0]  cfg_rsvd,
  input  logic [INC_W-1:0]  byte_inc,
  input  logic              sync_ack,
  output logic              sync_req,
  output logic              cfg_fault,
  output logic              lock_err,
  output logic [CODE_W-1:0] cur_code
);
  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       hit;
  logic       restart;
  logic       en;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign en = trace_en && cap_periodic;

  ssp_cfg u_cfg (
    .clk(clk), .rst_n(rst_s), .trace_en(trace_en), .cap_periodic(cap_periodic),
    .cap_mask(cap_mask), .wr(cfg_wr), .wr_code(cfg_code), .wr_rsvd(cfg_rsvd),
    .code_q(cur_code), .fault_q(cfg_fault), .lock_q(lock_err)
  );

  ssp_bytectr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_s), .trace_en(trace_en), .inc(byte_inc),
    .restart(restart), .code(cur_code), .hit(hit)
  );

  ssp_req u_req (
    .clk(clk), .rst_n(rst_s), .en(en), .hit(hit), .ack(sync_ack),
    .req_q(sync_req), .restart(restart)
  );
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk
  import ssp_pkg::*;
(
  input logic              clk,
  input logic              rst_s,
  input logic              trace_en,
  input logic              cap_periodic,
  input logic [NCODES-1:0] cap_mask,
  input logic              cfg_wr,
  input logic [CODE_W-1:0] cfg_code,
  input logic [RSV_W-1:0]  cfg_rsvd,
  input logic              sync_ack,
  input logic              sync_req,
  input logic              cfg_fault,
  input logic              lock_err,
  input logic [CODE_W-1:0] cur_code
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_s)
    sync_req && !sync_ack && trace_en && cap_periodic |=> sync_req);

  p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_s)
    sync_req && sync_ack |=> !sync_req);

  p_nocap_r6: assert property (@(posedge clk) disable iff (!rst_s)
    !cap_periodic |=> !sync_req);

  p_unsup_r7: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_wr && !trace_en && !cap_mask[cfg_code] |=> cfg_fault && $stable(cur_code));

  p_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_wr && !trace_en && (cfg_rsvd != '0) |=> cfg_fault && $stable(cur_code));

  p_lockwr_r9: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_wr && trace_en |=> lock_err && !cfg_fault && $stable(cur_code));

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_s)
    lock_err |=> lock_err);

  p_off_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !trace_en |=> !sync_req);

  p_nocap_code_r11: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_wr && !trace_en && !cap_periodic && (cfg_code != '0) |=> cfg_fault);
endmodule

bind ssp_top ssp_chk u_chk (
  .clk(clk), .rst_s(rst_s), .trace_en(trace_en), .cap_periodic(cap_periodic),
  .cap_mask(cap_mask), .cfg_wr(cfg_wr), .cfg_code(cfg_code), .cfg_rsvd(cfg_rsvd),
  .sync_ack(sync_ack), .sync_req(sync_req), .cfg_fault(cfg_fault),
  .lock_err(lock_err), .cur_code(cur_code)
);

// File: tb/sim_ssp_top.sv
`timescale 1ns/1ps
module sim_ssp_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trace_en, cap_periodic, cfg_wr, sync_ack;
  logic [15:0] cap_mask;
  logic [3:0]  cfg_code, cfg_rsvd, cur_code;
  logic [4:0]  byte_inc;
  logic        sync_req, cfg_fault, lock_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  string tag = "R1";

  // reference state
  logic [31:0] m_tot, m_base;
  logic        m_req, m_fault, m_lock;
  logic [3:0]  m_code;

  always #2.5 clk = ~clk;

  ssp_top u0 (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .cap_periodic(cap_periodic),
    .cap_mask(cap_mask), .cfg_wr(cfg_wr), .cfg_code(cfg_code), .cfg_rsvd(cfg_rsvd),
    .byte_inc(byte_inc), .sync_ack(sync_ack), .sync_req(sync_req),
    .cfg_fault(cfg_fault), .lock_err(lock_err), .cur_code(cur_code)
  );

  function automatic logic [31:0] period_of(input logic [3:0] c);
    return 32'd2048 << c;
  endfunction

  function automatic logic [4:0] clamp(input logic [4:0] v);
    return (v > 5'd16) ? 5'd16 : v;
  endfunction

  function automatic logic write_ok(input logic [3:0] c, input logic [3:0] rs,
                                    input logic cap, input logic [15:0] mask);
    return (rs == 4'd0) && mask[c] && (cap || c == 4'd0);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic en, taken;
    logic [31:0] since;
    en    = trace_en && cap_periodic;
    taken = m_req && sync_ack;
    since = m_tot - m_base;
    m_fault = 1'b0;
    if (cfg_wr) begin
      if (trace_en) m_lock = 1'b1;
      else if (!write_ok(cfg_code, cfg_rsvd, cap_periodic, cap_mask)) m_fault = 1'b1;
    end
    if (!en || taken) m_base = m_tot;
    m_req = (!en || taken) ? 1'b0 : (m_req || since >= period_of(m_code));
    if (trace_en) m_tot = m_tot + 32'(clamp(byte_inc));
    if (cfg_wr && !trace_en && write_ok(cfg_code, cfg_rsvd, cap_periodic, cap_mask))
      m_code = cfg_code;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(32'(sync_req),  32'(m_req),   "sync_req");
    chk(32'(cfg_fault), 32'(m_fault), "cfg_fault");
    chk(32'(lock_err),  32'(m_lock),  "lock_err");
    chk(32'(cur_code),  32'(m_code),  "cur_code");
    cfg_wr = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; trace_en = 0; cap_periodic = 1; cap_mask = 16'hFFFF;
    cfg_wr = 0; cfg_code = 0; cfg_rsvd = 0; byte_inc = 0; sync_ack = 0;
    m_tot = 0; m_base = 0; m_req = 0; m_fault = 0; m_lock = 0; m_code = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    tag = "R1";
    chk(32'(sync_req), 0, "sync_req"); chk(32'(cfg_fault), 0, "cfg_fault");
    chk(32'(lock_err), 0, "lock_err"); chk(32'(cur_code), 0, "cur_code");

    // R2: steady 16 bytes/cycle, code 0 -> 2048 bytes
    tag = "R2"; trace_en = 1; byte_inc = 5'd16;
    repeat (127) cyc();
    chk(32'(sync_req), 0, "no req before 2048 bytes");
    repeat (2) cyc();
    chk(32'(sync_req), 1, "req after 2048 bytes");
    // R3: held without ack
    tag = "R3"; repeat (5) cyc();
    sync_ack = 1; cyc(); sync_ack = 0;
    chk(32'(sync_req), 0, "ack clears");
    // R4: rebased at ack, late ack moves next deadline
    tag = "R4"; repeat (140) cyc();

    // R10: disable with pending request, then resume
    tag = "R10"; trace_en = 0; cyc(); chk(32'(sync_req), 0, "dropped when off");
    repeat (3) cyc(); trace_en = 1; repeat (130) cyc();

    // R9: write while tracing
    tag = "R9"; cfg_wr = 1; cfg_code = 4'd2; cyc(); repeat (3) cyc();

    // R7: unsupported code
    tag = "R7"; trace_en = 0; cap_mask = 16'hFFDF; cfg_wr = 1; cfg_code = 4'd5; cyc(); cyc();
    // R8: reserved bits nonzero
    tag = "R8"; cfg_wr = 1; cfg_code = 4'd1; cfg_rsvd = 4'h4; cyc(); cfg_rsvd = 0; cyc();
    // R11: capability off
    tag = "R11"; cap_periodic = 0; cfg_wr = 1; cfg_code = 4'd1; cyc();
    cfg_wr = 1; cfg_code = 4'd0; cyc();
    // R6: no requests without capability
    tag = "R6"; trace_en = 1; repeat (300) cyc();
    chk(32'(sync_req), 0, "no req with cap off");
    cap_periodic = 1; trace_en = 0; cfg_wr = 1; cfg_code = 4'd1; cfg_rsvd = 0; cyc();

    // R5: random increments (incl. clamped 17), random acks and config
    tag = "R5"; trace_en = 1;
    for (int i = 0; i < 8000; i++) begin
      byte_inc = 5'($urandom % 18);
      sync_ack = ($urandom % 4) == 0;
      if (($urandom % 400) == 0) trace_en = ~trace_en;
      if (($urandom % 30) == 0) begin
        cfg_wr   = 1;
        cfg_code = 4'($urandom % 3);
        cfg_rsvd = (($urandom % 8) == 0) ? 4'h1 : 4'h0;
      end
      cyc();
    end
    cfg_rsvd = 0; sync_ack = 0; byte_inc = 0;
    summary();
  end
endmodule